// File: doc/BRIEF.md
# Polyphase Fractional Sample Delay

This block delays a stream of signed 16-bit samples by a programmable amount of whole sample periods plus eighths of a sample period. A 263-entry shift register holds the recent accepted samples. The whole part of the delay picks where an eight-tap window starts along that register. The fractional part picks one of eight short coefficient branches.

The branches come from a 64-tap interpolating prototype. Its coefficients are reordered so that branch `p` holds every eighth coefficient, starting at coefficient `p`. Only the selected branch is multiplied and summed for each sample.

A new delay setting is written through a strobe. The setting is held until the next accepted sample, so that every output is computed from one branch and one window position. The pipeline depth does not depend on the setting: each output appears a fixed number of clock cycles after its input.

Top module: `pp_frac_delay`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is 0. The active and pending delay settings are 0, and every stored sample is 0.
- R2: `out_valid` equals `in_valid` from exactly 4 clock cycles earlier, for every delay setting.
- R3: `ctl_word[10:3]` is the whole delay D (0 to 255) and `ctl_word[2:0]` is the fraction p. Counted in accepted samples, the total delay from input to output is D + 4 + p/8 samples.
- R4: The prototype coefficient with index k (0 to 63) belongs to branch k mod 8, at tap k div 8. For fraction d = p/8, taps 3, 4, 5 and 6 hold the cubic Lagrange weights -d(d-1)(d-2)/6, (d+1)(d-1)(d-2)/2, -(d+1)d(d-2)/2 and (d+1)d(d-1)/6. These are stored as signed 16-bit values with 14 fraction bits, rounded to nearest. All other taps are 0.
- R5: With p = 0 the branch is a single weight of 1.0 at tap 4. The output then equals the input sample exactly, D + 4 samples later.
- R6: Output sample n equals the sum over taps t of coef[p][t] times x[n-D-t]. The sum is kept at full precision. It is then rounded by adding 2^13 and shifting right arithmetically by 14, and saturated to the range -32768 to 32767.
- R7: A word presented with `ctl_load` is captured. It takes effect from the first accepted sample in a later cycle. Samples accepted before that use the previous setting.
- R8: A cycle with `in_valid` low shifts no sample into the store. `out_data` keeps its last value while `out_valid` is low.
- R9: For a slow sine input at 1/32 of the sample rate, the output matches the sine shifted by D + 4 + p/8 samples to within 40 LSB.
- R10: The largest whole delay, D = 255, works with every fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_data | input | 16 | Signed input sample |
| ctl_load | input | 1 | Capture strobe for the delay word |
| ctl_word | input | 11 | Delay word: whole part and fraction |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Signed delayed sample |

## Verification
An impulse with p = 0 must come out unchanged at exactly D + 4 samples, including at D = 255. An off-by-one in the window index or a missing pipeline stage would move the peak or shrink it. A sine through every fraction exposes branches that are reordered or mirrored, because each of those shifts the phase by a multiple of an eighth of a sample. Alternating full-scale patterns push the sum past the range of 16 bits, so missing saturation would show up as wrap-around.

Strobes arriving during a stream or between gapped samples catch a setting applied in mid-sample or lost. Idle input cycles catch a store that shifts without a valid sample.

// File: rtl/pp_frac_delay.sv
module pp_frac_delay #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CF = 14,
  parameter int PH = 8,
  parameter int NT = 8,
  parameter int ND = 256,
  parameter int IW = $clog2(ND),
  parameter int FW = $clog2(PH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 ctl_load,
  input  logic [IW+FW-1:0]     ctl_word,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int LN = ND + NT - 1;
  localparam int PW = DW + CW;
  localparam int SW = PW + $clog2(NT) + 1;
  localparam int CT = NT / 2;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (CF - 1);
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  function automatic logic signed [CW-1:0] tap_coef(input int p, input int t);
    longint d, l, n, den, s;
    d = longint'(p);
    l = longint'(PH);
    den = 6 * l * l * l;
    case (t - CT)
      -1:      n = -d * (d - l) * (d - 2 * l);
      0:       n = 3 * (d + l) * (d - l) * (d - 2 * l);
      1:       n = -3 * (d + l) * d * (d - 2 * l);
      2:       n = (d + l) * d * (d - l);
      default: n = 0;
    endcase
    s = n * (longint'(1) <<< CF);
    if (s >= 0) s = (s + den / 2) / den;
    else        s = -((-s + den / 2) / den);
    return CW'(s);
  endfunction

  logic signed [CW-1:0] ctab [PH][NT];
  for (genvar gp = 0; gp < PH; gp++) begin : g_ph
    for (genvar gt = 0; gt < NT; gt++) begin : g_tap
      assign ctab[gp][gt] = tap_coef(gp, gt);
    end
  end

  logic signed [DW-1:0] smp [LN];
  logic [IW+FW-1:0] pend, act;
  logic ld_pend;
  logic v1, v2, v3;
  logic signed [PW-1:0] prod [NT];
  logic signed [SW-1:0] sum, acc, rnd, shr;
  logic signed [DW-1:0] sat;

  wire [IW-1:0] a_int  = act[IW+FW-1:FW];
  wire [FW-1:0] a_frac = act[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LN; i++) smp[i] <= '0;
    end else if (in_valid) begin
      smp[0] <= in_data;
      for (int i = 1; i < LN; i++) smp[i] <= smp[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      act     <= '0;
      ld_pend <= 1'b0;
    end else begin
      if (in_valid && ld_pend) act <= pend;
      if (ctl_load) begin
        pend    <= ctl_word;
        ld_pend <= 1'b1;
      end else if (in_valid) begin
        ld_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) prod[t] <= '0;
    end else if (v1) begin
      for (int t = 0; t < NT; t++)
        prod[t] <= PW'(smp[int'(a_int) + t]) * PW'(ctab[a_frac][t]);
    end
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < NT; t++) sum = sum + SW'(prod[t]);
  end

  assign rnd = acc + HALF;
  assign shr = rnd >>> CF;
  assign sat = (shr > MAXV) ? MAXV[DW-1:0] : (shr < MINV) ? MINV[DW-1:0] : shr[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      v3        <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      v3        <= v2;
      out_valid <= v3;
      if (v2) acc <= sum;
      if (v3) out_data <= sat;
    end
  end

  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2
  AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(act)); // R7
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> (ld_pend && pend == $past(ctl_word))); // R7
  AST_APPLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_pend) |=> (act == $past(pend))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v3 |=> $stable(out_data)); // R8
endmodule

// File: tb/test_pp_frac_delay.sv
`timescale 1ns/1ps
module test_pp_frac_delay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic ctl_load = 1'b0;
  logic [10:0] ctl_word = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  pp_frac_delay i_pp_frac_delay (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ctl_load(ctl_load), .ctl_word(ctl_word),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int hist [0:262];
  int act_m = 0, pend_m = 0, flag_m = 0;
  int ev [1:4];
  int ed [1:4];
  int hold_m = 0;
  int obuf [0:8191];
  int ocnt = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  string tag = "R6";

  function automatic int bcoef(input int p, input int t);
    real d, w, r;
    d = p / 8.0;
    case (t)
      3: w = -d * (d - 1.0) * (d - 2.0) / 6.0;
      4: w = (d + 1.0) * (d - 1.0) * (d - 2.0) / 2.0;
      5: w = -(d + 1.0) * d * (d - 2.0) / 2.0;
      6: w = (d + 1.0) * d * (d - 1.0) / 6.0;
      default: w = 0.0;
    endcase
    r = w * 16384.0;
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int ref_out(input int w);
    longint s;
    int dd, pp;
    dd = w / 8;
    pp = w % 8;
    s = 0;
    for (int t = 0; t < 8; t++) s += longint'(bcoef(pp, t)) * longint'(hist[dd + t]);
    s = (s + 8192) >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s got %0d expected %0d", r, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 263; i++) hist[i] = 0;
      act_m = 0; pend_m = 0; flag_m = 0; hold_m = 0;
      for (int i = 1; i <= 4; i++) begin ev[i] = 0; ed[i] = 0; end
    end else begin
      int y;
      y = 0;
      if (in_valid) begin
        if (flag_m != 0) act_m = pend_m;
        for (int i = 262; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'(in_data);
        y = ref_out(act_m);
      end
      if (ctl_load) begin pend_m = int'(ctl_word); flag_m = 1; end
      else if (in_valid) flag_m = 0;
      ev[4] = ev[3]; ed[4] = ed[3];
      ev[3] = ev[2]; ed[3] = ed[2];
      ev[2] = ev[1]; ed[2] = ed[1];
      ev[1] = int'(in_valid); ed[1] = y;
      if (ev[4] != 0) hold_m = ed[4];
    end
  end

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk(int'(out_valid) == ev[4], "R2", "out_valid", int'(out_valid), ev[4]);
      if (ev[4] != 0) chk(int'(out_data) == ed[4], tag, "out_data", int'(out_data), ed[4]);
      else chk(int'(out_data) == hold_m, "R8", "held out_data", int'(out_data), hold_m);
      if (out_valid) begin
        obuf[ocnt % 8192] = int'(out_data);
        ocnt++;
      end
    end
  end

  task automatic put(input bit v, input int d, input bit ld, input int w);
    in_valid = v;
    in_data = 16'(d);
    ctl_load = ld;
    ctl_word = 11'(w);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 0, 1'b0, 0);
  endtask

  task automatic set_ctl(input int dd, input int pp);
    put(1'b0, 0, 1'b1, dd * 8 + pp);
    idle(1);
  endtask

  task automatic impulse(input int dd, input int pp, input int amp, input string r);
    int base;
    set_ctl(dd, pp);
    for (int i = 0; i < 263; i++) put(1'b1, 0, 1'b0, 0);
    idle(6);
    base = ocnt;
    put(1'b1, amp, 1'b0, 0);
    for (int i = 0; i < dd + 12; i++) put(1'b1, 0, 1'b0, 0);
    idle(6);
    for (int j = 0; j <= dd + 11; j++) begin
      int e, t;
      longint s;
      t = j - dd;
      e = 0;
      if (t >= 0 && t < 8) begin
        s = (longint'(bcoef(pp, t)) * amp + 8192) >>> 14;
        e = int'(s);
      end
      if (e != 0 || j == dd + 4 || j == dd + 3)
        chk(obuf[(base + j) % 8192] == e, r, "impulse response", obuf[(base + j) % 8192], e);
    end
  endtask

  task automatic sine(input int dd, input int pp, input string r);
    int base, n, worst;
    real e, w;
    n = 330;
    w = 2.0 * 3.14159265358979 / 32.0;
    set_ctl(dd, pp);
    idle(6);
    base = ocnt;
    for (int i = 0; i < n; i++) put(1'b1, $rtoi(12000.0 * $sin(w * i) + (($sin(w * i) >= 0.0) ? 0.5 : -0.5)), 1'b0, 0);
    idle(6);
    worst = 0;
    for (int j = 290; j < n; j++) begin
      int diff;
      e = 12000.0 * $sin(w * (j - dd - 4 - pp / 8.0));
      diff = obuf[(base + j) % 8192] - $rtoi(e);
      if (diff < 0) diff = -diff;
      if (diff > worst) worst = diff;
    end
    chk(worst <= 40, r, "sine phase error LSB", worst, 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog run did not complete got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int mx, mn, base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_data == 16'sd0, "R1", "out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    put(1'b1, 1234, 1'b0, 0);
    idle(5);
    chk(obuf[0] == 0, "R1", "first output from zeroed store", obuf[0], 0);

    tag = "R5";
    impulse(0, 0, 20000, "R5");
    impulse(17, 0, -31000, "R5");
    tag = "R4";
    impulse(3, 4, 16000, "R4");
    impulse(9, 1, -12345, "R4");
    impulse(5, 7, 30000, "R4");
    tag = "R10";
    impulse(255, 0, 22222, "R10");
    impulse(255, 5, 22222, "R10");

    tag = "R9";
    for (int p = 0; p < 8; p++) sine(6 + p, p, "R9");
    sine(255, 3, "R9");
    sine(0, 6, "R3");

    tag = "R6";
    set_ctl(0, 4);
    idle(6);
    base = ocnt;
    for (int k = 0; k < 10; k++) begin
      put(1'b1, -32768, 1'b0, 0); put(1'b1, 32767, 1'b0, 0);
      put(1'b1, 32767, 1'b0, 0);  put(1'b1, -32768, 1'b0, 0);
      put(1'b1, 32767, 1'b0, 0);  put(1'b1, -32768, 1'b0, 0);
      put(1'b1, -32768, 1'b0, 0); put(1'b1, 32767, 1'b0, 0);
    end
    idle(6);
    mx = -100000; mn = 100000;
    for (int j = base; j < ocnt; j++) begin
      if (obuf[j % 8192] > mx) mx = obuf[j % 8192];
      if (obuf[j % 8192] < mn) mn = obuf[j % 8192];
    end
    chk(mx == 32767, "R6", "positive saturation", mx, 32767);
    chk(mn == -32768, "R6", "negative saturation", mn, -32768);

    tag = "R7";
    set_ctl(2, 0);
    for (int i = 0; i < 40; i++) begin
      bit ld;
      ld = (i % 7) == 3;
      put(1'b1, int'($urandom_range(0, 40000)) - 20000, ld, int'($urandom_range(0, 2047)));
      if (i % 5 == 0) put(1'b0, 0, (i % 10) == 0, int'($urandom_range(0, 2047)));
    end
    put(1'b0, 0, 1'b1, 8 * 40 + 2);
    put(1'b1, 500, 1'b1, 8 * 1 + 6);
    put(1'b1, -700, 1'b0, 0);
    put(1'b1, 900, 1'b0, 0);
    idle(6);

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      int d;
      d = int'($urandom_range(0, 65535)) - 32768;
      if ($urandom_range(0, 15) == 0) d = ($urandom_range(0, 1) != 0) ? 32767 : -32768;
      put($urandom_range(0, 9) < 7, d, $urandom_range(0, 39) == 0, int'($urandom_range(0, 2047)));
    end
    idle(8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule